// File: doc/BRIEF.md
# Read Data Window Centering Calibrator

This block is a calibration sequencer for a memory read path. It finds the middle of the passing region of a 6-bit read-capture phase tap. After a start pulse it first copies a fixed training pattern from an on-chip pattern store to external memory. It does this through a simple request port that carries command, address and write data, and that has a ready handshake. Next it steps the tap and reads the pattern back, one word at a time, a programmable number of times at each setting. It compares every returned word against the stored pattern.

There are two sweeps. The first is a descent that starts from a tap handed over by the previous calibration stage. It moves down one step at a time until a tap fails. The second is an edge search that starts from tap 0. It records the first passing tap as the low edge. It then records the first failing tap above it, or the top tap, as the high edge. Finally the block loads the midpoint of the two edges and raises `done`. If no tap passes anywhere, it raises `error` together with `done` and loads no midpoint. The per-bit data delay settings of the earlier stage are left alone, because the block has no port that reaches them.

The control is one state machine. Its states are:
- `S_IDLE`: waits for start.
- `S_WR_REQ`: sends pattern writes.
- `S_TAP_SET`: drives a new tap and pulses `tap_load`.
- `S_SETTLE`: waits for the delay line to settle.
- `S_RD_REQ`: sends one read command.
- `S_RD_WAIT`: waits for the returned word and compares it.
- `S_JUDGE`: decides pass or fail for the tap and picks the next tap.
- `S_CALC`: computes the midpoint.
- `S_APPLY`: latches the midpoint into the tap register.
- `S_FINAL`: loads the midpoint and sets `done`.

The transitions are:
- start: `S_IDLE` to `S_WR_REQ`.
- last write accepted: to `S_TAP_SET`.
- settle expired: `S_SETTLE` to `S_RD_REQ`.
- read accepted: to `S_RD_WAIT`.
- word returned: back to `S_RD_REQ`, or to `S_JUDGE` after the last word of the last sample.
- next tap: `S_JUDGE` to `S_TAP_SET`.
- edges found: `S_JUDGE` to `S_CALC`, then `S_APPLY`, then `S_FINAL`, then `S_IDLE`.
- no window: `S_JUDGE` to `S_IDLE` with `error`.

The sweep phase register takes three values:
- `PH_DESCEND`: the descent.
- `PH_LOW`: searching for the low edge.
- `PH_HIGH`: searching for the high edge.

Top module: `rdwin_center_cal`

## Requirements
- R1: After reset `done`, `error`, `cmd_valid` and `tap_load` are 0 and `tap_value` is 0.
- R2: On `start` in idle the block issues PAT_DEPTH writes (`cmd_write`=1), with addresses 0 upward, each carrying the pattern word at that address. A command with `cmd_ready` low keeps `cmd_valid`, address, write flag and data unchanged.
- R3: The first tap loaded after the writes equals `init_tap`. While a tap passes and is above 0, the next tap loaded is one lower. The descent stops at the first failing tap, or at tap 0.
- R4: After every `tap_load` pulse at least SETTLE_CYC cycles pass before the next read command. Reads are one at a time: a new read is issued only after the previous word has returned on `rd_valid`.
- R5: Each tap is judged over N full readings of the pattern, one read per address, where N is `sample_cnt`, and a `sample_cnt` of 0 counts as 1. A tap passes only if every returned word equals its pattern word.
- R6: The edge search loads taps from 0 upward. The first passing tap is reported on `left_edge`.
- R7: After the low edge, the search continues upward. The first failing tap is reported on `right_edge`; if every tap up to 63 passes, `right_edge` is 63.
- R8: On success the block loads `tap_value` = (`left_edge` + `right_edge`) >> 1 with one more `tap_load` pulse, then sets `done`=1 with `error`=0.
- R9: If no tap from 0 to 63 passes, the block sets `error`=1 and `done`=1 after loading tap 63, and issues no further `tap_load`.
- R10: `done`, `error` and `tap_value` hold until the next `start`. A `start` pulse while a calibration runs has no effect. A `start` in idle clears `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration (taken only in idle) |
| init_tap | input | TAP_W | Tap inherited from the previous stage |
| sample_cnt | input | SCNT_W | Pattern readings per tap (0 means 1) |
| pat_addr | output | AW | Pattern store read address |
| pat_data | input | DW | Pattern store word at `pat_addr`, same cycle |
| cmd_valid | output | 1 | Memory command request |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | AW | Command address |
| cmd_wdata | output | DW | Write data |
| cmd_ready | input | 1 | Command accepted this cycle |
| rd_valid | input | 1 | Read data return strobe |
| rd_data | input | DW | Returned read word |
| tap_value | output | TAP_W | Phase tap driven to the delay line |
| tap_load | output | 1 | One-cycle pulse when `tap_value` is applied |
| left_edge | output | TAP_W | Low edge of the passing window |
| right_edge | output | TAP_W | High edge of the passing window |
| done | output | 1 | Calibration finished |
| error | output | 1 | No passing tap found |

## Verification
Two decisions can land in the same judgement: capturing the low edge and ending the search at the top tap. The bench provokes this with a passing window that holds only tap 63. The run must report 63 for both edges and load 63 as the midpoint, rather than running past the tap range or raising `error`. A second overlap is provoked by a tap that fails only on the last of three readings. A bench that read only once per tap would place the low edge one tap too low, so the reported edge shows whether every reading was judged.

// File: rtl/rdwin_pkg.sv
package rdwin_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WR_REQ,
        S_TAP_SET,
        S_SETTLE,
        S_RD_REQ,
        S_RD_WAIT,
        S_JUDGE,
        S_CALC,
        S_APPLY,
        S_FINAL
    } cal_state_t;

    typedef enum logic [1:0] {
        PH_DESCEND,
        PH_LOW,
        PH_HIGH
    } sweep_phase_t;

endpackage

// File: rtl/rdwin_settle.sv
module rdwin_settle #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic quiet
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (arm) begin
            cnt_q <= CW'(CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign quiet = (cnt_q == '0) && !arm;

endmodule

// File: rtl/rdwin_judge.sv
module rdwin_judge #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          cmp_en,
    input  logic [DW-1:0] got,
    input  logic [DW-1:0] want,
    output logic          miss
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss <= 1'b0;
        end else if (clr) begin
            miss <= 1'b0;
        end else if (cmp_en && (got != want)) begin
            miss <= 1'b1;
        end
    end

endmodule

// File: rtl/rdwin_center.sv
module rdwin_center #(
    parameter int TAP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             calc,
    input  logic [TAP_W-1:0] lo,
    input  logic [TAP_W-1:0] hi,
    output logic [TAP_W-1:0] mid
);
    logic [TAP_W:0] sum;

    assign sum = {1'b0, lo} + {1'b0, hi};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid <= '0;
        end else if (calc) begin
            mid <= sum[TAP_W:1];
        end
    end

endmodule

// File: rtl/rdwin_center_cal.sv
module rdwin_center_cal
    import rdwin_pkg::*;
#(
    parameter int DW         = 16,
    parameter int PAT_DEPTH  = 8,
    parameter int TAP_W      = 6,
    parameter int SCNT_W     = 4,
    parameter int SETTLE_CYC = 4,
    localparam int AW        = (PAT_DEPTH > 1) ? $clog2(PAT_DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TAP_W-1:0]  init_tap,
    input  logic [SCNT_W-1:0] sample_cnt,
    output logic [AW-1:0]     pat_addr,
    input  logic [DW-1:0]     pat_data,
    output logic              cmd_valid,
    output logic              cmd_write,
    output logic [AW-1:0]     cmd_addr,
    output logic [DW-1:0]     cmd_wdata,
    input  logic              cmd_ready,
    input  logic              rd_valid,
    input  logic [DW-1:0]     rd_data,
    output logic [TAP_W-1:0]  tap_value,
    output logic              tap_load,
    output logic [TAP_W-1:0]  left_edge,
    output logic [TAP_W-1:0]  right_edge,
    output logic              done,
    output logic              error
);
    localparam logic [TAP_W-1:0] TOP_TAP  = {TAP_W{1'b1}};
    localparam logic [AW-1:0]    LAST_IDX = AW'(PAT_DEPTH - 1);

    cal_state_t        state_q, state_d;
    sweep_phase_t      phase_q;
    logic [TAP_W-1:0]  tap_q;
    logic [TAP_W-1:0]  left_q, right_q;
    logic [AW-1:0]     idx_q;
    logic [SCNT_W-1:0] samp_q, nsamp_q;
    logic              done_q, err_q;

    logic settle_quiet;
    logic tap_miss;
    logic [TAP_W-1:0] mid;
    logic word_back, last_word, last_samp, at_top;

    assign word_back = (state_q == S_RD_WAIT) && rd_valid;
    assign last_word = (idx_q == LAST_IDX);
    assign last_samp = (samp_q == nsamp_q - SCNT_W'(1));
    assign at_top    = (tap_q == TOP_TAP);

    rdwin_settle #(.CYC(SETTLE_CYC)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (state_q == S_TAP_SET),
        .quiet (settle_quiet)
    );

    rdwin_judge #(.DW(DW)) u_judge (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state_q == S_TAP_SET),
        .cmp_en (word_back),
        .got    (rd_data),
        .want   (pat_data),
        .miss   (tap_miss)
    );

    rdwin_center #(.TAP_W(TAP_W)) u_center (
        .clk   (clk),
        .rst_n (rst_n),
        .calc  (state_q == S_CALC),
        .lo    (left_q),
        .hi    (right_q),
        .mid   (mid)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_WR_REQ;
            S_WR_REQ:  if (cmd_ready && last_word) state_d = S_TAP_SET;
            S_TAP_SET: state_d = S_SETTLE;
            S_SETTLE:  if (settle_quiet) state_d = S_RD_REQ;
            S_RD_REQ:  if (cmd_ready) state_d = S_RD_WAIT;
            S_RD_WAIT: begin
                if (rd_valid) begin
                    state_d = (last_word && last_samp) ? S_JUDGE : S_RD_REQ;
                end
            end
            S_JUDGE: begin
                unique case (phase_q)
                    PH_DESCEND: state_d = S_TAP_SET;
                    PH_LOW: begin
                        if (!tap_miss && at_top) state_d = S_CALC;
                        else if (tap_miss && at_top) state_d = S_IDLE;
                        else state_d = S_TAP_SET;
                    end
                    PH_HIGH: state_d = (tap_miss || at_top) ? S_CALC : S_TAP_SET;
                    default: state_d = S_IDLE;
                endcase
            end
            S_CALC:  state_d = S_APPLY;
            S_APPLY: state_d = S_FINAL;
            S_FINAL: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // datapath and output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_DESCEND;
            tap_q   <= '0;
            left_q  <= '0;
            right_q <= '0;
            idx_q   <= '0;
            samp_q  <= '0;
            nsamp_q <= SCNT_W'(1);
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        done_q  <= 1'b0;
                        err_q   <= 1'b0;
                        idx_q   <= '0;
                        phase_q <= PH_DESCEND;
                        nsamp_q <= (sample_cnt == '0) ? SCNT_W'(1) : sample_cnt;
                    end
                end
                S_WR_REQ: begin
                    if (cmd_ready) begin
                        if (last_word) tap_q <= init_tap;
                        else           idx_q <= idx_q + AW'(1);
                    end
                end
                S_TAP_SET: begin
                    idx_q  <= '0;
                    samp_q <= '0;
                end
                S_RD_WAIT: begin
                    if (rd_valid) begin
                        if (last_word) begin
                            idx_q <= '0;
                            if (!last_samp) samp_q <= samp_q + SCNT_W'(1);
                        end else begin
                            idx_q <= idx_q + AW'(1);
                        end
                    end
                end
                S_JUDGE: begin
                    unique case (phase_q)
                        PH_DESCEND: begin
                            if (!tap_miss && tap_q != '0) begin
                                tap_q <= tap_q - TAP_W'(1);
                            end else begin
                                phase_q <= PH_LOW;
                                tap_q   <= '0;
                            end
                        end
                        PH_LOW: begin
                            if (!tap_miss) begin
                                left_q <= tap_q;
                                if (at_top) begin
                                    right_q <= tap_q;
                                end else begin
                                    phase_q <= PH_HIGH;
                                    tap_q   <= tap_q + TAP_W'(1);
                                end
                            end else if (at_top) begin
                                err_q  <= 1'b1;
                                done_q <= 1'b1;
                            end else begin
                                tap_q <= tap_q + TAP_W'(1);
                            end
                        end
                        PH_HIGH: begin
                            if (tap_miss || at_top) right_q <= tap_q;
                            else tap_q <= tap_q + TAP_W'(1);
                        end
                        default: ;
                    endcase
                end
                S_APPLY: tap_q  <= mid;
                S_FINAL: done_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assign pat_addr   = idx_q;
    assign cmd_valid  = (state_q == S_WR_REQ) || (state_q == S_RD_REQ);
    assign cmd_write  = (state_q == S_WR_REQ);
    assign cmd_addr   = idx_q;
    assign cmd_wdata  = pat_data;
    assign tap_value  = tap_q;
    assign tap_load   = (state_q == S_TAP_SET) || (state_q == S_FINAL);
    assign left_edge  = left_q;
    assign right_edge = right_q;
    assign done       = done_q;
    assign error      = err_q;

    assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr)
                                       && $stable(cmd_write) && $stable(cmd_wdata)));

    assert_descend_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TAP_SET && phase_q == PH_DESCEND && $past(state_q) == S_JUDGE)
        |-> (tap_q == $past(tap_q) - TAP_W'(1)));

    assert_settle_before_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_write) |-> settle_quiet);

    assert_mid_inside_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FINAL) |-> (tap_q >= left_q && tap_q <= right_q));

    assert_error_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    assert_hold_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(tap_value) && $stable(error)));

endmodule

// File: tb/sim_rdwin_center_cal.sv
module sim_rdwin_center_cal;
    localparam int DW = 16, DEPTH = 8, TW = 6, SW = 4, SETTLE = 4, AW = 3;
    localparam int NV = 6;
    // {init 6, samples 4, lo 7, hi 7, flaky 7, stall 1, exp_mid 7}; lo=64: no window, 127: none/error
    localparam logic [38:0] VEC [NV] = '{
        {6'd30, 4'd2, 7'd20, 7'd40, 7'd127, 1'b0, 7'd30},
        {6'd5,  4'd1, 7'd0,  7'd10, 7'd127, 1'b1, 7'd5},
        {6'd50, 4'd3, 7'd12, 7'd45, 7'd12,  1'b0, 7'd29},
        {6'd63, 4'd0, 7'd40, 7'd63, 7'd127, 1'b1, 7'd51},
        {6'd63, 4'd1, 7'd63, 7'd63, 7'd127, 1'b0, 7'd63},
        {6'd10, 4'd2, 7'd64, 7'd64, 7'd127, 1'b1, 7'd127}
    };

    logic clk = 0, rst_n = 0, start = 0;
    logic [TW-1:0] init_tap = 0;
    logic [SW-1:0] sample_cnt = 0;
    logic [AW-1:0] pat_addr, cmd_addr;
    logic [DW-1:0] pat_data, cmd_wdata, rd_data;
    logic cmd_valid, cmd_write, cmd_ready, rd_valid, tap_load, done, error;
    logic [TW-1:0] tap_value, left_edge, right_edge;

    int n_chk = 0, n_fail = 0;
    int cfg_lo = 0, cfg_hi = 0, cfg_fl = 127, cfg_ns = 1;
    logic cfg_stall = 0, meas_clr = 0;
    int cyc = 0, loads = 0, reads = 0, writes = 0, first_load = -1, gap = 0, min_gap = 1000, rsl = 0;
    logic [DW-1:0] mem [DEPTH];
    logic rv1 = 0, rv2 = 0;
    logic [DW-1:0] rd1 = 0, rd2 = 0;

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] pat_fn(input int a);
        return 16'hA5C3 ^ DW'(a * 16'h3B1D);
    endfunction

    assign pat_data  = pat_fn(int'(pat_addr));
    assign cmd_ready = cfg_stall ? ((cyc % 5) != 3) : 1'b1;
    assign rd_valid  = rv2;
    assign rd_data   = rd2;

    rdwin_center_cal u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .init_tap(init_tap), .sample_cnt(sample_cnt),
        .pat_addr(pat_addr), .pat_data(pat_data), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .tap_value(tap_value), .tap_load(tap_load), .left_edge(left_edge),
        .right_edge(right_edge), .done(done), .error(error)
    );

    // memory and delay-line model
    always @(posedge clk) begin
        logic bad;
        int t;
        cyc <= cyc + 1;
        rv2 <= rv1;
        rd2 <= rd1;
        rv1 <= 1'b0;
        if (meas_clr) begin
            loads <= 0; reads <= 0; writes <= 0; first_load <= -1; min_gap <= 1000; gap <= 0; rsl <= 0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            gap <= gap + 1;
            if (tap_load) begin
                loads <= loads + 1;
                rsl <= 0;
                gap <= 0;
                if (first_load < 0) first_load <= int'(tap_value);
            end
            if (cmd_valid && cmd_ready && cmd_write) begin
                mem[cmd_addr] <= cmd_wdata;
                writes <= writes + 1;
            end
            if (cmd_valid && cmd_ready && !cmd_write) begin
                t = int'(tap_value);
                bad = !(t >= cfg_lo && t <= cfg_hi) || (t == cfg_fl && (rsl / DEPTH) == cfg_ns - 1);
                rv1 <= 1'b1;
                rd1 <= mem[cmd_addr] ^ (bad ? 16'h0100 : 16'h0000);
                reads <= reads + 1;
                rsl <= rsl + 1;
                if (rsl == 0 && gap < min_gap) min_gap <= gap;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit passes(input int t, input int lo, input int hi, input int fl);
        return (t >= lo) && (t <= hi) && (t != fl);
    endfunction

    task automatic wait_done(output bit ok);
        ok = 0;
        for (int k = 0; k < 40000; k++) begin
            @(negedge clk);
            if (done) begin ok = 1; break; end
        end
    endtask

    task automatic run_vec(input logic [38:0] v, input bit poke_start);
        int init, ns, nse, lo, hi, fl, emid, t, dec, left, right, eload, eread;
        bit err, ok;
        init = int'(v[38:33]); ns = int'(v[32:29]); lo = int'(v[28:22]); hi = int'(v[21:15]);
        fl = int'(v[14:8]); emid = int'(v[6:0]);
        nse = (ns == 0) ? 1 : ns;
        // independent model of the sweep
        t = init;
        while (passes(t, lo, hi, fl) && t > 0) t--;
        dec = init - t + 1;
        left = -1;
        for (int k = 0; k < 64; k++) if (left < 0 && passes(k, lo, hi, fl)) left = k;
        err = (left < 0);
        right = 63;
        if (!err) for (int k = 63; k > left; k--) if (!passes(k, lo, hi, fl)) right = k;
        eload = err ? dec + 64 : dec + right + 2;
        eread = (err ? dec + 64 : dec + right + 1) * nse * DEPTH;

        @(negedge clk);
        cfg_lo = lo; cfg_hi = hi; cfg_fl = fl; cfg_ns = nse; cfg_stall = v[7];
        init_tap = TW'(init); sample_cnt = SW'(ns); meas_clr = 1;
        @(negedge clk);
        meas_clr = 0; start = 1;
        @(negedge clk);
        start = 0;
        chk(done == 0, "R10 start clears done", int'(done), 0);
        if (poke_start) begin
            repeat (300) @(negedge clk);
            start = 1;
            @(negedge clk);
            start = 0;
        end
        wait_done(ok);
        chk(ok, "R9/R8 done reached", int'(ok), 1);
        chk(writes == DEPTH, "R2 write count", writes, DEPTH);
        for (int i = 0; i < DEPTH; i++)
            chk(mem[i] == pat_fn(i), "R2 written pattern", int'(mem[i]), int'(pat_fn(i)));
        chk(first_load == init, "R3 first tap", first_load, init);
        chk(loads == eload, "R3/R6 tap load count", loads, eload);
        chk(reads == eread, "R5 read count", reads, eread);
        chk(min_gap - 1 >= SETTLE, "R4 settle gap", min_gap - 1, SETTLE);
        chk(error == err, "R9 error flag", int'(error), int'(err));
        if (!err) begin
            chk(int'(left_edge) == left, "R6 left edge", int'(left_edge), left);
            chk(int'(right_edge) == right, "R7 right edge", int'(right_edge), right);
            chk(int'(tap_value) == emid, "R8 center tap", int'(tap_value), emid);
        end else begin
            chk(int'(tap_value) == 63, "R9 tap left at 63", int'(tap_value), 63);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int hold_tap, hold_loads;
        repeat (3) @(negedge clk);
        chk(done == 0 && error == 0, "R1 flags after reset", int'({done, error}), 0);
        chk(cmd_valid == 0 && tap_load == 0, "R1 idle command", int'({cmd_valid, tap_load}), 0);
        chk(tap_value == 0, "R1 tap after reset", int'(tap_value), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(cmd_valid == 0, "R1 no command before start", int'(cmd_valid), 0);

        for (int v = 0; v < NV; v++) run_vec(VEC[v], 1'b0);

        // R10: start pulse mid-run is ignored, results then hold
        run_vec(VEC[0], 1'b1);
        hold_tap = int'(tap_value);
        hold_loads = loads;
        repeat (30) @(negedge clk);
        chk(done == 1, "R10 done holds", int'(done), 1);
        chk(int'(tap_value) == hold_tap, "R10 tap holds", int'(tap_value), hold_tap);
        chk(loads == hold_loads, "R10 no extra loads", loads, hold_loads);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule